// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is the target side of an I2C bus with a 7-bit address. It samples the SCL and SDA bus lines with the system clock. It finds Start and Stop conditions and shifts in the address byte. When the address is its own, it acknowledges and then either receives bytes into a single buffer register or sends bytes from it. Its outputs are open-drain pull-down enables: a 1 on `sda_oe` or `scl_oe` pulls the line low.

The local side works through strobes. `wr_strobe` writes the buffer and, during a read transfer, loads the transmit shifter. `rd_strobe` marks the buffer as read. `release_strobe` lets go of a stretched SCL. `irq_clr` clears the per-byte interrupt and the overflow flag. A read transfer always stretches SCL after the address and after every byte the controller acknowledges. This gives the local side time to supply data. During a write transfer, stretching after each byte happens only when `stretch_en` is high.

State machine states and transitions:
- ST_IDLE waits for a Start.
- ST_ADDR shifts in the address byte. On the eighth falling edge it moves to ST_ADDR_ACK if the address matches and neither `buf_full` nor `rx_ovf` is set. Otherwise it returns to ST_IDLE.
- ST_ADDR_ACK drives the acknowledge. On the ninth falling edge it goes to ST_TX_BIT for a read or to ST_RX_BIT for a write.
- ST_RX_BIT shifts in a data byte and then goes to ST_RX_ACK.
- ST_RX_ACK drives or withholds the acknowledge and then returns to ST_RX_BIT.
- ST_TX_BIT shifts out eight bits and then goes to ST_TX_ACK.
- ST_TX_ACK samples the controller's acknowledge. It goes to ST_TX_BIT on an acknowledge and to ST_IDLE on a not-acknowledge.
- In any state, a Stop leads to ST_IDLE and a Start leads to ST_ADDR.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset, `sda_oe`, `scl_oe`, `irq`, `buf_full`, `rx_ovf` and `rw_flag` are all 0.
- R2: When the address byte matches `dev_addr` and its last bit (read/write, 1 = read) is 0, the block pulls SDA low during the ninth clock. It also clears `rw_flag`, loads the whole address byte into the buffer (`rd_data`) and sets `buf_full`.
- R3: In a write transfer, each data byte is shifted in MSB first on SCL rising edges. It is loaded into the buffer and acknowledged, and `buf_full` is set. A pulse on `rd_strobe` clears `buf_full`.
- R4: When the address byte matches and its read/write bit is 1, the block acknowledges and sets `rw_flag`. It then holds SCL low after the ninth clock, whatever the value of `stretch_en`.
- R5: In a read transfer, the byte written with `wr_strobe` is sent MSB first. SDA changes only after SCL falling edges, so it is stable while SCL is high.
- R6: With `stretch_en` = 1, SCL is held low after the ninth clock of a write address and of every received data byte. It stays low until a `release_strobe` pulse. With `stretch_en` = 0, a write transfer never holds SCL.
- R7: When the controller gives a not-acknowledge on the ninth clock of a read byte, the transfer ends. `rw_flag` and `buf_full` clear, SDA and SCL are released, and the block waits for a Start.
- R8: When the controller acknowledges a read byte, SCL is held low again until the local side writes a new byte and pulses `release_strobe`.
- R9: `irq` sets on the ninth falling SCL edge of every address or data byte that the block takes part in. It stays set until `irq_clr`.
- R10: When `buf_full` or `rx_ovf` is set as an address byte ends, the block does not acknowledge. The buffer is left unchanged and `irq` is not set.
- R11: When a data byte completes while `buf_full` is set, `rx_ovf` sets, the byte is not acknowledged and the buffer keeps its old value. `irq_clr` clears `rx_ovf`.
- R12: An address byte that does not match is not acknowledged and does not set `irq`. After it, or after a Stop, both lines are released and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Own 7-bit bus address |
| stretch_en | input | 1 | Hold SCL after each write-transfer byte |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_data | input | 8 | Byte to place in the buffer |
| wr_strobe | input | 1 | Write `wr_data` to the buffer and transmit shifter |
| rd_strobe | input | 1 | Buffer read; clears `buf_full` |
| release_strobe | input | 1 | Release a held SCL |
| irq_clr | input | 1 | Clear `irq` and `rx_ovf` |
| rd_data | output | 8 | Buffer contents |
| irq | output | 1 | Per-byte interrupt flag |
| buf_full | output | 1 | Buffer holds an unread byte |
| rx_ovf | output | 1 | Receive overflow flag |
| rw_flag | output | 1 | Read/write bit of the last matched address |

## Verification
The hardest case to reach is an address that arrives while `rx_ovf` is set. The flag only appears after a data byte lands in an unread buffer, and the usual end-of-byte clean-up (`irq_clr`) wipes it. So the overflow test sends a byte into a still-full buffer and leaves `irq` uncleared. It then opens a new transfer to check the not-acknowledge, and only after that clears the flags one at a time to see the acknowledge return. The stretching cases need a bus model in which SCL is the wired-AND of the bench's driver and `scl_oe`, and in which the bench's driver waits for the line to rise. That lets the bench hold a transfer open and check that SCL stays low for many cycles before the release.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX_BIT,
        ST_RX_ACK,
        ST_TX_BIT,
        ST_TX_ACK
    } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_raw, sda_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[1];
    assign sda_s     = synced[0];
    assign scl_rise  = synced[1] & ~prev[1];
    assign scl_fall  = ~synced[1] & prev[1];
    assign bus_start = synced[1] & prev[1] & prev[0] & ~synced[0];
    assign bus_stop  = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              stretch_en,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              buf_full,
    input  logic              rx_ovf,
    input  logic              rw_flag,
    input  logic              wr_strobe,
    input  logic [BYTE_W-1:0] wr_data,
    output tgt_state_t        state_o,
    output logic [BYTE_W-1:0] sr_o,
    output logic              ld_addr,
    output logic              ld_rx,
    output logic              ovf_set,
    output logic              irq_set,
    output logic              hold_set,
    output logic              end_clear,
    output logic              idle,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    tgt_state_t        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr;
    logic              ack_drive;
    logic              mack_n;
    logic              bus_ev;
    logic              byte_in;
    logic              addr_hit;
    logic              blocked;

    assign bus_ev   = bus_start | bus_stop;
    assign byte_in  = scl_fall && (cnt == LAST_RX);
    assign addr_hit = (sr[BYTE_W-1 -: ADDR_W] == dev_addr);
    assign blocked  = buf_full | rx_ovf;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (bus_stop) begin
            nxt = ST_IDLE;
        end else if (bus_start) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_in) nxt = (addr_hit && !blocked) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = rw_flag ? ST_TX_BIT : ST_RX_BIT;
                ST_RX_BIT:   if (byte_in) nxt = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) nxt = ST_RX_BIT;
                ST_TX_BIT:   if (scl_fall && cnt == LAST_TX) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) nxt = mack_n ? ST_IDLE : ST_TX_BIT;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // bit counter, shifter and acknowledge bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            sr        <= '0;
            ack_drive <= 1'b0;
            mack_n    <= 1'b1;
        end else if (bus_ev) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_RX_BIT: begin
                    if (scl_rise && cnt != LAST_RX) begin
                        sr  <= {sr[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end
                    if (byte_in) begin
                        cnt       <= '0;
                        ack_drive <= (state == ST_ADDR) ? (addr_hit && !blocked) : !buf_full;
                    end
                end
                ST_TX_BIT: begin
                    if (scl_fall) begin
                        sr  <= {sr[BYTE_W-2:0], 1'b0};
                        cnt <= (cnt == LAST_TX) ? '0 : cnt + 1'b1;
                    end else if (wr_strobe) begin
                        sr <= wr_data;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) mack_n <= sda_s;
                end
                default: ;
            endcase
        end
    end

    // outputs and events
    always_comb begin
        ld_addr   = 1'b0;
        ld_rx     = 1'b0;
        ovf_set   = 1'b0;
        irq_set   = 1'b0;
        hold_set  = 1'b0;
        end_clear = 1'b0;
        sda_oe    = 1'b0;
        idle      = 1'b0;
        unique case (state)
            ST_IDLE: idle = 1'b1;
            ST_ADDR: ld_addr = !bus_ev && byte_in && addr_hit && !blocked;
            ST_ADDR_ACK: begin
                sda_oe   = 1'b1;
                irq_set  = !bus_ev && scl_fall;
                hold_set = !bus_ev && scl_fall && (rw_flag || stretch_en);
            end
            ST_RX_BIT: begin
                ld_rx   = !bus_ev && byte_in && !buf_full;
                ovf_set = !bus_ev && byte_in && buf_full;
            end
            ST_RX_ACK: begin
                sda_oe   = ack_drive;
                irq_set  = !bus_ev && scl_fall;
                hold_set = !bus_ev && scl_fall && stretch_en;
            end
            ST_TX_BIT: sda_oe = !sr[BYTE_W-1];
            ST_TX_ACK: begin
                irq_set   = !bus_ev && scl_fall;
                hold_set  = !bus_ev && scl_fall && !mack_n;
                end_clear = !bus_ev && scl_fall && mack_n;
            end
            default: ;
        endcase
    end

    assign state_o = state;
    assign sr_o    = sr;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              ld_addr,
    input  logic              ld_rx,
    input  logic              ovf_set,
    input  logic              irq_set,
    input  logic              hold_set,
    input  logic              end_clear,
    input  logic              idle,
    input  logic              wr_strobe,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_strobe,
    input  logic              release_strobe,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] buf_q,
    output logic              buf_full,
    output logic              rx_ovf,
    output logic              rw_flag,
    output logic              irq,
    output logic              hold
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
            rx_ovf   <= 1'b0;
            rw_flag  <= 1'b0;
            irq      <= 1'b0;
            hold     <= 1'b0;
        end else begin
            if (wr_strobe) buf_q <= wr_data;
            if (ld_addr || ld_rx) buf_q <= byte_in;

            if (rd_strobe) buf_full <= 1'b0;
            if (ld_addr || ld_rx) buf_full <= 1'b1;
            if (end_clear) buf_full <= 1'b0;

            if (ld_addr) rw_flag <= byte_in[0];
            if (end_clear) rw_flag <= 1'b0;

            if (irq_clr) rx_ovf <= 1'b0;
            if (ovf_set) rx_ovf <= 1'b1;

            if (irq_clr) irq <= 1'b0;
            if (irq_set) irq <= 1'b1;

            if (release_strobe || idle) hold <= 1'b0;
            if (hold_set) hold <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              stretch_en,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_strobe,
    input  logic              rd_strobe,
    input  logic              release_strobe,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq,
    output logic              buf_full,
    output logic              rx_ovf,
    output logic              rw_flag
);
    logic              scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    tgt_state_t        st;
    logic [BYTE_W-1:0] sr;
    logic              ld_addr, ld_rx, ovf_set, irq_set, hold_set, end_clear, idle;
    logic              hold;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_tgt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_addr   (dev_addr),
        .stretch_en (stretch_en),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .buf_full   (buf_full),
        .rx_ovf     (rx_ovf),
        .rw_flag    (rw_flag),
        .wr_strobe  (wr_strobe),
        .wr_data    (wr_data),
        .state_o    (st),
        .sr_o       (sr),
        .ld_addr    (ld_addr),
        .ld_rx      (ld_rx),
        .ovf_set    (ovf_set),
        .irq_set    (irq_set),
        .hold_set   (hold_set),
        .end_clear  (end_clear),
        .idle       (idle),
        .sda_oe     (sda_oe)
    );

    i2c_tgt_regs u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .byte_in        (sr),
        .ld_addr        (ld_addr),
        .ld_rx          (ld_rx),
        .ovf_set        (ovf_set),
        .irq_set        (irq_set),
        .hold_set       (hold_set),
        .end_clear      (end_clear),
        .idle           (idle),
        .wr_strobe      (wr_strobe),
        .wr_data        (wr_data),
        .rd_strobe      (rd_strobe),
        .release_strobe (release_strobe),
        .irq_clr        (irq_clr),
        .buf_q          (rd_data),
        .buf_full       (buf_full),
        .rx_ovf         (rx_ovf),
        .rw_flag        (rw_flag),
        .irq            (irq),
        .hold           (hold)
    );

    assign scl_oe = hold;
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
    import i2c_tgt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input tgt_state_t        state,
    input logic              scl_s,
    input logic              scl_fall,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              end_clear,
    input logic              rw_flag,
    input logic              buf_full,
    input logic              rx_ovf,
    input logic              irq,
    input logic              irq_clr,
    input logic              release_strobe,
    input logic              wr_strobe,
    input logic [BYTE_W-1:0] rd_data,
    input logic              sda_oe,
    input logic              scl_oe
);
    // R4: a read address always leads to a held clock
    a_r4_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && rw_flag && scl_fall && !bus_start && !bus_stop) |=> scl_oe);

    // R6: a held clock stays held until the release strobe
    a_r6_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && !release_strobe) |=> scl_oe);

    // R5: SDA drive does not move while the synchronized SCL stays high
    a_r5_sda_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R7: a controller not-acknowledge returns to idle with status cleared
    a_r7_nack_end: assert property (@(posedge clk) disable iff (!rst_n)
        end_clear |=> (!rw_flag && !buf_full && state == ST_IDLE));

    // R9: the interrupt flag is sticky until cleared
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R10: a blocked buffer prevents the address acknowledge
    a_r10_blocked_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && (buf_full || rx_ovf)) |=> state != ST_ADDR_ACK);

    // R11: a full buffer keeps its contents while a byte is received
    a_r11_buf_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX_BIT && buf_full && !wr_strobe) |=> $stable(rd_data));

    // R12: idle releases both lines
    a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
    a_r12_idle_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !scl_oe);
endmodule

bind i2c_tgt_stretch i2c_tgt_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state          (st),
    .scl_s          (scl_s),
    .scl_fall       (scl_fall),
    .bus_start      (bus_start),
    .bus_stop       (bus_stop),
    .end_clear      (end_clear),
    .rw_flag        (rw_flag),
    .buf_full       (buf_full),
    .rx_ovf         (rx_ovf),
    .irq            (irq),
    .irq_clr        (irq_clr),
    .release_strobe (release_strobe),
    .wr_strobe      (wr_strobe),
    .rd_data        (rd_data),
    .sda_oe         (sda_oe),
    .scl_oe         (scl_oe)
);

// File: tb/test_i2c_tgt_stretch.sv
`timescale 1ns/1ps
module test_i2c_tgt_stretch;
    localparam int H = 10;
    localparam logic [6:0] ADDR = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stretch_en = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [7:0] wr_data = '0;
    logic       wr_strobe = 1'b0, rd_strobe = 1'b0, release_strobe = 1'b0, irq_clr = 1'b0;
    logic       scl_oe, sda_oe, irq, buf_full, rx_ovf, rw_flag;
    logic [7:0] rd_data;
    logic       scl_line, sda_line;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    i2c_tgt_stretch i_i2c_tgt_stretch (
        .clk(clk), .rst_n(rst_n), .dev_addr(ADDR), .stretch_en(stretch_en),
        .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .wr_data(wr_data), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
        .release_strobe(release_strobe), .irq_clr(irq_clr), .rd_data(rd_data),
        .irq(irq), .buf_full(buf_full), .rx_ovf(rx_ovf), .rw_flag(rw_flag)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic pulse_wr(input logic [7:0] d);
        wr_data = d; wr_strobe = 1'b1; wclk(1); wr_strobe = 1'b0; wclk(1);
    endtask
    task automatic pulse_rd;
        rd_strobe = 1'b1; wclk(1); rd_strobe = 1'b0; wclk(1);
    endtask
    task automatic pulse_rel;
        release_strobe = 1'b1; wclk(1); release_strobe = 1'b0; wclk(1);
    endtask
    task automatic pulse_clr;
        irq_clr = 1'b1; wclk(1); irq_clr = 1'b0; wclk(1);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; m_scl = 1'b1; wclk(H);
        m_sda = 1'b0; wclk(H);
        m_scl = 1'b0; wclk(H);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wclk(H);
        m_scl = 1'b1; wait (scl_line === 1'b1); wclk(H);
        m_sda = 1'b1; wclk(H);
    endtask

    // one clock: drive b, sample SDA early and late in the high phase
    task automatic bit_io(input logic b, output logic s1, output logic s2);
        m_sda = b; wclk(H);
        m_scl = 1'b1;
        wait (scl_line === 1'b1);
        wclk(2);  s1 = sda_line;
        wclk(H-2); s2 = sda_line;
        m_scl = 1'b0; wclk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack_n);
        logic x, y;
        for (int i = 7; i >= 0; i--) bit_io(b[i], x, y);
        bit_io(1'b1, ack_n, y);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d, output logic stable_ok);
        logic s1, s2;
        stable_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s1, s2);
            d[i] = s1;
            if (s1 !== s2) stable_ok = 1'b0;
        end
        bit_io(nack, s1, s2);
    endtask

    task automatic t_reset;
        chk("R1", "reset outputs", {2'b0, sda_oe, scl_oe, irq, buf_full, rx_ovf, rw_flag}, 8'h00);
    endtask

    task automatic t_write_plain;
        logic a;
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        chk("R2", "address ack", {7'b0, a}, 8'h00);
        chk("R2", "rw_flag", {7'b0, rw_flag}, 8'h00);
        chk("R2", "buffer holds address", rd_data, {ADDR, 1'b0});
        chk("R2", "buf_full", {7'b0, buf_full}, 8'h01);
        chk("R9", "irq after address", {7'b0, irq}, 8'h01);
        chk("R6", "no hold when stretch off", {7'b0, scl_oe}, 8'h00);
        wclk(30);
        chk("R9", "irq sticky", {7'b0, irq}, 8'h01);
        pulse_clr; pulse_rd;
        chk("R3", "rd_strobe clears buf_full", {7'b0, buf_full}, 8'h00);
        send_byte(8'hA5, a);
        chk("R3", "data ack", {7'b0, a}, 8'h00);
        chk("R3", "data in buffer", rd_data, 8'hA5);
        chk("R3", "buf_full after data", {7'b0, buf_full}, 8'h01);
        chk("R9", "irq after data", {7'b0, irq}, 8'h01);
        bus_stop;
        chk("R12", "lines free after stop", {6'b0, sda_oe, scl_oe}, 8'h00);
        pulse_clr; pulse_rd;
    endtask

    task automatic t_write_stretch;
        logic a;
        stretch_en = 1'b1;
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        chk("R6", "address ack", {7'b0, a}, 8'h00);
        chk("R6", "hold after write address", {7'b0, scl_oe}, 8'h01);
        wclk(40);
        chk("R6", "hold persists", {7'b0, scl_oe}, 8'h01);
        pulse_clr; pulse_rd;
        chk("R6", "hold persists without release", {7'b0, scl_oe}, 8'h01);
        pulse_rel;
        chk("R6", "release frees SCL", {7'b0, scl_oe}, 8'h00);
        send_byte(8'h5C, a);
        chk("R3", "stretched data", rd_data, 8'h5C);
        chk("R6", "hold after data byte", {7'b0, scl_oe}, 8'h01);
        pulse_rd; pulse_clr; pulse_rel;
        bus_stop;
        stretch_en = 1'b0;
    endtask

    task automatic t_read;
        logic a, ok;
        logic [7:0] d;
        bus_start;
        send_byte({ADDR, 1'b1}, a);
        chk("R4", "read address ack", {7'b0, a}, 8'h00);
        chk("R4", "rw_flag set", {7'b0, rw_flag}, 8'h01);
        chk("R4", "forced hold", {7'b0, scl_oe}, 8'h01);
        wclk(40);
        chk("R4", "forced hold persists", {7'b0, scl_oe}, 8'h01);
        pulse_clr; pulse_wr(8'h3C); pulse_rel;
        recv_byte(1'b0, d, ok);
        chk("R5", "first tx byte", d, 8'h3C);
        chk("R5", "SDA stable in high", {7'b0, ok}, 8'h01);
        chk("R9", "irq after tx byte", {7'b0, irq}, 8'h01);
        chk("R8", "hold after controller ack", {7'b0, scl_oe}, 8'h01);
        wclk(30);
        chk("R8", "hold persists", {7'b0, scl_oe}, 8'h01);
        pulse_clr; pulse_wr(8'hC3); pulse_rel;
        recv_byte(1'b1, d, ok);
        chk("R5", "second tx byte", d, 8'hC3);
        chk("R5", "SDA stable in high 2", {7'b0, ok}, 8'h01);
        chk("R7", "nack end state", {4'b0, sda_oe, scl_oe, rw_flag, buf_full}, 8'h00);
        bus_stop;
        pulse_clr;
    endtask

    task automatic t_mismatch;
        logic a;
        bus_start;
        send_byte({ADDR ^ 7'h01, 1'b0}, a);
        chk("R12", "mismatch nack", {7'b0, a}, 8'h01);
        chk("R12", "mismatch no irq", {7'b0, irq}, 8'h00);
        chk("R12", "mismatch lines free", {5'b0, sda_oe, scl_oe, buf_full}, 8'h00);
        bus_stop;
    endtask

    task automatic t_overflow;
        logic a;
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        chk("R11", "setup ack", {7'b0, a}, 8'h00);
        pulse_clr;
        send_byte(8'h11, a);
        chk("R11", "overflow byte nack", {7'b0, a}, 8'h01);
        chk("R11", "rx_ovf set", {7'b0, rx_ovf}, 8'h01);
        chk("R11", "buffer kept", rd_data, {ADDR, 1'b0});
        chk("R9", "irq on overflow byte", {7'b0, irq}, 8'h01);
        bus_stop;
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        chk("R10", "nack with overflow", {7'b0, a}, 8'h01);
        chk("R10", "buffer unchanged", rd_data, {ADDR, 1'b0});
        bus_stop;
        pulse_clr;
        chk("R11", "irq_clr clears rx_ovf", {7'b0, rx_ovf}, 8'h00);
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        chk("R10", "nack with buffer full", {7'b0, a}, 8'h01);
        chk("R10", "no irq when blocked", {7'b0, irq}, 8'h00);
        bus_stop;
        pulse_rd;
        bus_start;
        send_byte({ADDR, 1'b0}, a);
        chk("R10", "ack after unblock", {7'b0, a}, 8'h00);
        bus_stop;
        pulse_clr; pulse_rd;
    endtask

    initial begin
        wclk(4);
        rst_n = 1'b1;
        wclk(4);
        t_reset;
        t_write_plain;
        t_write_stretch;
        t_read;
        t_mismatch;
        t_overflow;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule